// File: doc/BRIEF.md
# Register Window Pointer Controller

This block holds the current window pointer of a windowed register file and the mode bits that travel with it. A pipeline hands it one request per cycle: step the window down, step it up, return from a trap, or load the whole status word. Each window move is checked against a per-window invalid mask. A move into a marked window is refused and reported as a trap code. A legal move updates the pointer.

The window count is the parameter `NWIN`, from 2 to 32, and pointer arithmetic wraps modulo that count. The invalid mask is a 32-bit register loaded through its own write port. The packed status word can be read at all times. A trap is reported as a one-cycle pulse with a two-bit code. The cycle that carries the pulse also shows the unchanged state.

Top module: `win_ptr_ctl`

## Requirements
- R1: After reset the pointer is 0, the mask is 0, no trap is pending, and the status word reads 0x0000_0080 (supervisor set, every other field clear).
- R2: A step-down request (`op_sel`=00) with no trap sets the pointer to pointer−1. From 0 it goes to NWIN−1.
- R3: A step-up request (`op_sel`=01) with no trap sets the pointer to pointer+1. From NWIN−1 it goes to 0.
- R4: A step-down whose target window has its mask bit set raises code 01 (overflow) and leaves all state unchanged.
- R5: A step-up whose target window has its mask bit set raises code 10 (underflow) and leaves all state unchanged.
- R6: A return-from-trap (`op_sel`=10) while trap-enable is 1 raises code 11 (illegal). It changes nothing, and this takes priority over a masked target.
- R7: A return-from-trap that succeeds does three things. It sets trap-enable to 1, steps the pointer up with wrap, and copies previous-supervisor into supervisor.
- R8: A return-from-trap with trap-enable 0 and a masked target raises code 10 and leaves trap-enable, supervisor and pointer unchanged.
- R9: A status write (`op_sel`=11) whose bits 4:0 are ≥ NWIN raises code 11 and changes nothing.
- R10: The status word layout is as follows. Condition codes are at 23:20, FP-enable at 12, interrupt level at 11:8, supervisor at 7, previous-supervisor at 6, trap-enable at 5 and the pointer at 4:0. All other bits read 0. A legal status write loads every one of these fields from the same positions.
- R11: `trap_valid` is high for exactly the one cycle after a refused request. A legal request or an idle cycle leaves it low.
- R12: A request uses the mask as it stood before the current cycle. A mask write issued in the same cycle takes effect from the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Request present this cycle |
| op_sel | input | 2 | 00 step down, 01 step up, 10 return-from-trap, 11 status write |
| op_wdata | input | 32 | Status word for a status write |
| mask_we | input | 1 | Load the invalid mask |
| mask_wdata | input | 32 | New invalid mask, bit n marks window n |
| mask_o | output | 32 | Current invalid mask |
| cwp_o | output | 5 | Current window pointer |
| status_o | output | 32 | Packed status word |
| trap_valid | output | 1 | Refused request, one-cycle pulse |
| trap_code | output | 2 | 01 overflow, 10 underflow, 11 illegal |

## Verification
Every result is one register stage from its request. The new pointer, status word, mask and trap pulse all appear after the rising edge that samples the request, and the pulse is gone after the next edge. The bench changes inputs on falling edges, reads all outputs at the next falling edge, and then checks one falling edge later that the trap pulse has dropped. Each expected value comes from the wrap and mask rules written out by hand, and the sequence passes through both wrap points and each trap cause in turn.

// File: rtl/win_ptr_ctl.sv
module win_ptr_ctl #(
  parameter int NWIN = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_valid,
  input  logic [1:0]  op_sel,
  input  logic [31:0] op_wdata,
  input  logic        mask_we,
  input  logic [31:0] mask_wdata,
  output logic [31:0] mask_o,
  output logic [4:0]  cwp_o,
  output logic [31:0] status_o,
  output logic        trap_valid,
  output logic [1:0]  trap_code
);
  localparam logic [4:0] LASTW = 5'(NWIN - 1);
  localparam logic [5:0] NW6   = 6'(NWIN);

  localparam logic [1:0] OP_DN = 2'b00, OP_UP = 2'b01, OP_RET = 2'b10, OP_WR = 2'b11;
  localparam logic [1:0] TC_OVF = 2'b01, TC_UNF = 2'b10, TC_ILL = 2'b11;

  logic [31:0] mask_q;
  logic [4:0]  cwp_q, cwp_d;
  logic [3:0]  cc_q, cc_d, pil_q, pil_d;
  logic        ef_q, ef_d, s_q, s_d, ps_q, ps_d, et_q, et_d;
  logic        tv_d;
  logic [1:0]  tc_d;

  logic [4:0] cwp_dn, cwp_up;
  assign cwp_dn = (cwp_q == 5'd0) ? LASTW : cwp_q - 5'd1;
  assign cwp_up = (cwp_q == LASTW) ? 5'd0 : cwp_q + 5'd1;

  logic unused_bits;
  assign unused_bits = ^{op_wdata[31:24], op_wdata[19:13]};

  always_comb begin
    cwp_d = cwp_q; cc_d = cc_q; pil_d = pil_q;
    ef_d = ef_q; s_d = s_q; ps_d = ps_q; et_d = et_q;
    tv_d = 1'b0; tc_d = 2'b00;
    if (op_valid) begin
      case (op_sel)
        OP_DN: begin
          if (mask_q[cwp_dn]) begin tv_d = 1'b1; tc_d = TC_OVF; end
          else cwp_d = cwp_dn;
        end
        OP_UP: begin
          if (mask_q[cwp_up]) begin tv_d = 1'b1; tc_d = TC_UNF; end
          else cwp_d = cwp_up;
        end
        OP_RET: begin
          if (et_q) begin tv_d = 1'b1; tc_d = TC_ILL; end
          else if (mask_q[cwp_up]) begin tv_d = 1'b1; tc_d = TC_UNF; end
          else begin
            et_d  = 1'b1;
            cwp_d = cwp_up;
            s_d   = ps_q;
          end
        end
        default: begin
          if ({1'b0, op_wdata[4:0]} >= NW6) begin tv_d = 1'b1; tc_d = TC_ILL; end
          else begin
            cc_d  = op_wdata[23:20];
            ef_d  = op_wdata[12];
            pil_d = op_wdata[11:8];
            s_d   = op_wdata[7];
            ps_d  = op_wdata[6];
            et_d  = op_wdata[5];
            cwp_d = op_wdata[4:0];
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0; cwp_q <= '0; cc_q <= '0; pil_q <= '0;
      ef_q <= 1'b0; s_q <= 1'b1; ps_q <= 1'b0; et_q <= 1'b0;
      trap_valid <= 1'b0; trap_code <= 2'b00;
    end else begin
      if (mask_we) mask_q <= mask_wdata;
      cwp_q <= cwp_d; cc_q <= cc_d; pil_q <= pil_d;
      ef_q <= ef_d; s_q <= s_d; ps_q <= ps_d; et_q <= et_d;
      trap_valid <= tv_d; trap_code <= tc_d;
    end
  end

  assign mask_o   = mask_q;
  assign cwp_o    = cwp_q;
  assign status_o = {8'h00, cc_q, 7'h00, ef_q, pil_q, s_q, ps_q, et_q, cwp_q};
endmodule

// File: rtl/win_ptr_ctl_chk.sv
module win_ptr_ctl_chk #(
  parameter int NWIN = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        op_valid,
  input logic [1:0]  op_sel,
  input logic [4:0]  cwp_o,
  input logic [31:0] status_o,
  input logic        trap_valid,
  input logic [1:0]  trap_code
);
  localparam logic [4:0] LASTW = 5'(NWIN - 1);

  AST_CWP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cwp_o <= LASTW); // R2

  AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel == 2'b00) |=> (trap_valid ||
      cwp_o == (($past(cwp_o) == 5'd0) ? LASTW : $past(cwp_o) - 5'd1))); // R2

  AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel == 2'b01) |=> (trap_valid ||
      cwp_o == (($past(cwp_o) == LASTW) ? 5'd0 : $past(cwp_o) + 5'd1))); // R3

  AST_TRAP_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> (cwp_o == $past(cwp_o) && status_o == $past(status_o))); // R4

  AST_RET_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel == 2'b10 && status_o[5]) |=> (trap_valid && trap_code == 2'b11)); // R6

  AST_RET_MODE_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel == 2'b10 && !status_o[5]) |=>
      (trap_valid || (status_o[5] && status_o[7] == $past(status_o[6])))); // R7

  AST_NO_TRAP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !trap_valid); // R11
endmodule

bind win_ptr_ctl win_ptr_ctl_chk #(.NWIN(NWIN)) u_chk (.*);

// File: tb/win_ptr_ctl_test.sv
module win_ptr_ctl_test;
  localparam int NWIN = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic [1:0] op_sel = 2'b00;
  logic [31:0] op_wdata = '0;
  logic mask_we = 1'b0;
  logic [31:0] mask_wdata = '0;
  logic [31:0] mask_o, status_o;
  logic [4:0] cwp_o;
  logic trap_valid;
  logic [1:0] trap_code;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  win_ptr_ctl #(.NWIN(NWIN)) uut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic request(input logic [1:0] sel, input logic [31:0] d,
                         input logic mw, input logic [31:0] m);
    op_valid = 1'b1; op_sel = sel; op_wdata = d;
    mask_we = mw; mask_wdata = m;
    @(negedge clk);
    op_valid = 1'b0; mask_we = 1'b0;
  endtask

  task automatic expect_ok(input string req, input logic [4:0] cwp, input logic [31:0] st);
    check(req, {31'd0, trap_valid}, 32'd0);
    check(req, {27'd0, cwp_o}, {27'd0, cwp});
    check(req, status_o, st);
  endtask

  task automatic expect_trap(input string req, input logic [1:0] code,
                             input logic [4:0] cwp, input logic [31:0] st);
    check(req, {31'd0, trap_valid}, 32'd1);
    check(req, {30'd0, trap_code}, {30'd0, code});
    check(req, {27'd0, cwp_o}, {27'd0, cwp});
    check(req, status_o, st);
    @(negedge clk);
    check("R11 pulse width", {31'd0, trap_valid}, 32'd0);
  endtask

  task automatic t_reset();
    check("R1 cwp", {27'd0, cwp_o}, 32'd0);
    check("R1 mask", mask_o, 32'd0);
    check("R1 status", status_o, 32'h0000_0080);
    check("R1 trap", {31'd0, trap_valid}, 32'd0);
  endtask

  task automatic t_wrap();
    request(2'b00, 0, 0, 0); expect_ok("R2 wrap down", 5'd7, 32'h87);
    request(2'b00, 0, 0, 0); expect_ok("R2 step down", 5'd6, 32'h86);
    request(2'b01, 0, 0, 0); expect_ok("R3 step up", 5'd7, 32'h87);
    request(2'b01, 0, 0, 0); expect_ok("R3 wrap up", 5'd0, 32'h80);
  endtask

  task automatic t_mask_traps();
    mask_we = 1'b1; mask_wdata = 32'h80; @(negedge clk); mask_we = 1'b0;
    check("R12 mask load", mask_o, 32'h80);
    request(2'b00, 0, 0, 0); expect_trap("R4 overflow", 2'b01, 5'd0, 32'h80);
    mask_we = 1'b1; mask_wdata = 32'h02; @(negedge clk); mask_we = 1'b0;
    request(2'b01, 0, 0, 0); expect_trap("R5 underflow", 2'b10, 5'd0, 32'h80);
  endtask

  task automatic t_status_write();
    request(2'b11, 32'h0000_0008, 0, 0); expect_trap("R9 bad cwp", 2'b11, 5'd0, 32'h80);
    request(2'b11, 32'h0FAF_F563, 0, 0); expect_ok("R10 load", 5'd3, 32'h00A0_1563);
  endtask

  task automatic t_return();
    mask_we = 1'b1; mask_wdata = 32'h10; @(negedge clk); mask_we = 1'b0;
    request(2'b10, 0, 0, 0); expect_trap("R6 illegal first", 2'b11, 5'd3, 32'h00A0_1563);
    request(2'b11, 32'h0000_0043, 0, 0); expect_ok("R10 load2", 5'd3, 32'h43);
    request(2'b10, 0, 0, 0); expect_trap("R8 masked return", 2'b10, 5'd3, 32'h43);
    mask_we = 1'b1; mask_wdata = 32'h0; @(negedge clk); mask_we = 1'b0;
    request(2'b10, 0, 0, 0); expect_ok("R7 return", 5'd4, 32'hE4);
  endtask

  task automatic t_mask_timing();
    request(2'b00, 0, 1'b1, 32'h08); expect_ok("R12 old mask used", 5'd3, 32'hE3);
    check("R12 mask now", mask_o, 32'h08);
    request(2'b00, 0, 0, 0); expect_ok("R2 unmasked", 5'd2, 32'hE2);
    request(2'b01, 0, 0, 0); expect_trap("R12 new mask used", 2'b10, 5'd2, 32'hE2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_wrap();
    t_mask_traps();
    t_status_write();
    t_return();
    t_mask_timing();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule